// File: doc/BRIEF.md
# Staged Soft-Start Power Sequencer

This block starts and stops the charge-pump supply of an electronic-paper panel. After a start pulse it reads four stage records of eight bytes each from a calibration memory. The records are read in order, from consecutive addresses beginning at a parameterised base (default 0x28). Each record drives a loop of register writes. Two 8-bit phase accumulators start at the record's initial values and take a signed step on every pass. A switch register is written before and after each phase write. An optional millisecond pause ends each pass.

When all four stages are done, the block waits for the panel's active-high ready line and then sends the update trigger. A stop pulse plays the fixed shut-down sequence. That sequence also waits for ready first.

Every register write leaves the block as a burst of bytes on a valid/ready port. The first byte of a burst is the register address and is flagged as a command. The bytes after it are data. Serial shifting is done downstream.

Top module: `softstart_seq`

## Requirements
- R1: For stage s (0 to 3, in that order) the block reads the eight bytes at addresses CAL_BASE+8*s+0 to +7 from a memory that returns data one clock after the address.
- R2: Record layout: byte 0 holds the format flag in bit 7 and the repeat count in bits 6..0. Bytes 1 and 2 are the low and high phase start values. Bytes 3 and 4 are their two's-complement steps. Byte 5 is the switch value for the start of a pass and byte 6 the switch value for its end. Byte 7 holds the delay-enable flag in bit 7 and the delay in milliseconds in bits 6..0.
- R3: Each pass emits three writes in this order: register 0x09 with the start switch value, then 0x51 with the low then the high accumulator, then 0x09 with the end switch value. The address byte of each write has wr_cmd_o=1 and its data bytes have wr_cmd_o=0.
- R4: Both accumulators are 8 bits wide and wrap modulo 256. The step is added before the 0x51 write, so the first value written is start+step.
- R5: With wr_ready_i held high, a pass that is not the last of its stage is followed by the next pass's first accepted byte. This happens 2 cycles after the end-switch data byte is accepted when the delay flag is 0, and delay*CLKS_PER_MS+3 cycles after it when the flag is 1.
- R6: A stage whose repeat count is 0 produces no writes.
- R7: A stage whose format flag is 0 ends the sequence with no further writes. It sets err_o, which stays high until the next accepted start or stop.
- R8: After the last stage the block writes register 0x15 = 0x3C, and it does so only after panel_rdy_i has been seen high.
- R9: On stop_i the block waits for panel_rdy_i high, then writes 0x09=0x7B, 0x05=0x5D and 0x09=0x7A. It then pauses 15 ms; with wr_ready_i high, the next byte is accepted 15*CLKS_PER_MS+2 cycles after the previous one. Last it writes 0x09=0x00.
- R10: While wr_valid_o is high and wr_ready_i is low, wr_valid_o, wr_byte_o and wr_cmd_o keep their values.
- R11: After reset busy_o, err_o and wr_valid_o are 0.
- R12: start_i and stop_i pulses that arrive while busy_o is high have no effect on the emitted stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Pulse: begin the power-up sequence |
| stop_i | input | 1 | Pulse: begin the shut-down sequence |
| panel_rdy_i | input | 1 | Panel ready, active high |
| cal_addr_o | output | CAL_AW | Calibration memory read address |
| cal_data_i | input | 8 | Calibration memory data, one cycle after the address |
| wr_valid_o | output | 1 | Write byte valid |
| wr_ready_i | input | 1 | Downstream accepts the byte |
| wr_cmd_o | output | 1 | 1 for a register address byte, 0 for a data byte |
| wr_byte_o | output | 8 | Write byte |
| busy_o | output | 1 | A sequence is in progress |
| err_o | output | 1 | Last power-up aborted on a bad format flag |

## Verification
A wrong repeat counter or a wrong accumulator shows at the ports within one pass. The repeat counter fault shows as an extra or missing 0x09/0x51/0x09 group. The accumulator fault shows as a wrong 0x51 data byte. A fault in the record fetch shows as wrong switch or phase values from the first write of the affected stage. Timer or sequencing faults show as pass-to-pass gaps that differ from the exact cycle counts required with ready held high, or as a trigger sent while ready is low. The stream is compared byte by byte against a model built from the memory contents, under both steady and random backpressure.

// File: rtl/ss_pkg.sv
package ss_pkg;

  typedef enum logic [4:0] {
    ST_IDLE, ST_LOAD, ST_CHECK, ST_SWA, ST_PH, ST_SWB, ST_DLY, ST_ITER,
    ST_NEXT, ST_RDY, ST_TRIG, ST_SRDY, ST_S1, ST_S2, ST_S3, ST_SDLY, ST_S4
  } seq_st_t;

  typedef struct packed {
    logic       fmt;
    logic [6:0] reps;
    logic [7:0] lo_init;
    logic [7:0] hi_init;
    logic [7:0] lo_step;
    logic [7:0] hi_step;
    logic [7:0] sw_start;
    logic [7:0] sw_end;
    logic       scale;
    logic [6:0] dly;
  } stage_t;

  localparam logic [7:0] REG_SWITCH = 8'h09;
  localparam logic [7:0] REG_PHASE  = 8'h51;
  localparam logic [7:0] REG_TRIG   = 8'h15;
  localparam logic [7:0] VAL_TRIG   = 8'h3C;
  localparam logic [7:0] REG_PWR    = 8'h05;
  localparam logic [7:0] OFF_SW1    = 8'h7B;
  localparam logic [7:0] OFF_PWR    = 8'h5D;
  localparam logic [7:0] OFF_SW2    = 8'h7A;
  localparam logic [7:0] OFF_SW3    = 8'h00;
  localparam logic [6:0] OFF_MS     = 7'd15;

endpackage

// File: rtl/ss_rst_sync.sv
module ss_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/ss_ms_timer.sv
module ss_ms_timer #(
  parameter int CLKS_PER_MS = 50000,
  parameter int MSW         = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [MSW-1:0] ms_in,
  output logic           expired
);
  localparam int SUBW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
  localparam logic [SUBW-1:0] SUB_LAST = SUBW'(CLKS_PER_MS - 1);

  logic [MSW-1:0]  ms_q, ms_d;
  logic [SUBW-1:0] sub_q, sub_d;

  always_comb begin
    ms_d  = ms_q;
    sub_d = sub_q;
    if (load) begin
      ms_d  = ms_in;
      sub_d = '0;
    end else if (ms_q != '0) begin
      if (sub_q == SUB_LAST) begin
        sub_d = '0;
        ms_d  = ms_q - MSW'(1);
      end else begin
        sub_d = sub_q + SUBW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms_q  <= '0;
      sub_q <= '0;
    end else begin
      ms_q  <= ms_d;
      sub_q <= sub_d;
    end
  end

  assign expired = (ms_q == '0);

  // R5: the millisecond count never jumps by more than one step
  assert_countdown_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && ms_q != '0) |=> (ms_q == $past(ms_q) || ms_q == $past(ms_q) - MSW'(1)));

  // R5: an expired timer stays expired until reloaded
  assert_stay_expired_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && expired) |=> expired);
endmodule

// File: rtl/ss_stage_fetch.sv
module ss_stage_fetch
  import ss_pkg::*;
#(
  parameter int              CAL_AW   = 8,
  parameter logic [CAL_AW-1:0] CAL_BASE = CAL_AW'(8'h28)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [1:0]        stage_idx,
  output logic [CAL_AW-1:0] cal_addr,
  input  logic [7:0]        cal_data,
  output logic              done,
  output stage_t            rec
);
  localparam int NBYTES = 8;

  logic [3:0] cnt_q, cnt_d;
  logic       cap_q;
  logic [2:0] cidx_q;
  logic       done_q;
  logic [7:0] bytes_q [NBYTES];

  always_comb begin
    cnt_d = cnt_q;
    if (go)             cnt_d = 4'd0;
    else if (!cnt_q[3]) cnt_d = cnt_q + 4'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= 4'd8;
      cap_q  <= 1'b0;
      cidx_q <= 3'd0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      cap_q  <= !cnt_q[3];
      cidx_q <= cnt_q[2:0];
      done_q <= cap_q && (cidx_q == 3'd7);
    end
  end

  always_ff @(posedge clk) begin
    if (cap_q) bytes_q[cidx_q] <= cal_data;
  end

  assign cal_addr = CAL_BASE + CAL_AW'({stage_idx, cnt_q[2:0]});
  assign done     = done_q;

  assign rec.fmt      = bytes_q[0][7];
  assign rec.reps     = bytes_q[0][6:0];
  assign rec.lo_init  = bytes_q[1];
  assign rec.hi_init  = bytes_q[2];
  assign rec.lo_step  = bytes_q[3];
  assign rec.hi_step  = bytes_q[4];
  assign rec.sw_start = bytes_q[5];
  assign rec.sw_end   = bytes_q[6];
  assign rec.scale    = bytes_q[7][7];
  assign rec.dly      = bytes_q[7][6:0];

  // R1: within one record fetch, addresses advance by exactly one
  assert_addr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_q[3] && cnt_q != 4'd0 && !$past(go)) |-> cal_addr == $past(cal_addr) + CAL_AW'(1));
endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
  import ss_pkg::*;
#(
  parameter int                CAL_AW      = 8,
  parameter logic [CAL_AW-1:0] CAL_BASE    = CAL_AW'(8'h28),
  parameter int                CLKS_PER_MS = 50000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              panel_rdy_i,
  output logic [CAL_AW-1:0] cal_addr_o,
  input  logic [7:0]        cal_data_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic              wr_cmd_o,
  output logic [7:0]        wr_byte_o,
  output logic              busy_o,
  output logic              err_o
);
  localparam int NSTAGE = 4;
  localparam logic [1:0] LAST_STAGE = 2'(NSTAGE - 1);

  logic    srst_n;
  seq_st_t state_q, state_d;
  logic [1:0] bidx_q, bidx_d, last_idx;
  logic [1:0] stage_q, stage_d;
  logic [6:0] reps_q, reps_d;
  logic [7:0] acc_lo_q, acc_lo_d, acc_hi_q, acc_hi_d;
  logic       err_q, err_d;
  logic       fetch_go, fetch_done;
  stage_t     rec;
  logic       tmr_load, tmr_exp;
  logic [6:0] tmr_ms;
  logic       emit, fire, fin;
  logic [7:0] b0, b1, b2;

  ss_rst_sync i_rst_sync (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  ss_stage_fetch #(.CAL_AW(CAL_AW), .CAL_BASE(CAL_BASE)) i_fetch (
    .clk(clk), .rst_n(srst_n), .go(fetch_go), .stage_idx(stage_q),
    .cal_addr(cal_addr_o), .cal_data(cal_data_i), .done(fetch_done), .rec(rec)
  );

  ss_ms_timer #(.CLKS_PER_MS(CLKS_PER_MS), .MSW(7)) i_timer (
    .clk(clk), .rst_n(srst_n), .load(tmr_load), .ms_in(tmr_ms), .expired(tmr_exp)
  );

  // byte selection for the write in progress
  always_comb begin
    emit     = 1'b1;
    b0       = REG_SWITCH;
    b1       = 8'h00;
    b2       = 8'h00;
    last_idx = 2'd1;
    case (state_q)
      ST_SWA:  b1 = rec.sw_start;
      ST_PH:   begin b0 = REG_PHASE; b1 = acc_lo_q; b2 = acc_hi_q; last_idx = 2'd2; end
      ST_SWB:  b1 = rec.sw_end;
      ST_TRIG: begin b0 = REG_TRIG; b1 = VAL_TRIG; end
      ST_S1:   b1 = OFF_SW1;
      ST_S2:   begin b0 = REG_PWR; b1 = OFF_PWR; end
      ST_S3:   b1 = OFF_SW2;
      ST_S4:   b1 = OFF_SW3;
      default: emit = 1'b0;
    endcase
  end

  assign fire       = emit && wr_ready_i;
  assign fin        = fire && (bidx_q == last_idx);
  assign wr_valid_o = emit;
  assign wr_cmd_o   = emit && (bidx_q == 2'd0);
  assign wr_byte_o  = (bidx_q == 2'd0) ? b0 : ((bidx_q == 2'd1) ? b1 : b2);
  assign busy_o     = (state_q != ST_IDLE);
  assign err_o      = err_q;

  // next-state logic
  always_comb begin
    state_d  = state_q;
    stage_d  = stage_q;
    reps_d   = reps_q;
    acc_lo_d = acc_lo_q;
    acc_hi_d = acc_hi_q;
    err_d    = err_q;
    fetch_go = 1'b0;
    tmr_load = 1'b0;
    tmr_ms   = rec.dly;
    bidx_d   = bidx_q;
    if (fire) bidx_d = fin ? 2'd0 : bidx_q + 2'd1;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          err_d    = 1'b0;
          stage_d  = 2'd0;
          fetch_go = 1'b1;
          state_d  = ST_LOAD;
        end else if (stop_i) begin
          err_d   = 1'b0;
          state_d = ST_SRDY;
        end
      end
      ST_LOAD:  if (fetch_done) state_d = ST_CHECK;
      ST_CHECK: begin
        if (!rec.fmt) begin
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end else if (rec.reps == 7'd0) begin
          state_d = ST_NEXT;
        end else begin
          reps_d   = rec.reps;
          acc_lo_d = rec.lo_init;
          acc_hi_d = rec.hi_init;
          state_d  = ST_SWA;
        end
      end
      ST_SWA: if (fin) begin
        acc_lo_d = acc_lo_q + rec.lo_step;
        acc_hi_d = acc_hi_q + rec.hi_step;
        state_d  = ST_PH;
      end
      ST_PH:  if (fin) state_d = ST_SWB;
      ST_SWB: if (fin) begin
        if (rec.scale) begin
          tmr_load = 1'b1;
          state_d  = ST_DLY;
        end else begin
          state_d = ST_ITER;
        end
      end
      ST_DLY:  if (tmr_exp) state_d = ST_ITER;
      ST_ITER: begin
        if (reps_q == 7'd1) begin
          state_d = ST_NEXT;
        end else begin
          reps_d  = reps_q - 7'd1;
          state_d = ST_SWA;
        end
      end
      ST_NEXT: begin
        if (stage_q == LAST_STAGE) begin
          state_d = ST_RDY;
        end else begin
          stage_d  = stage_q + 2'd1;
          fetch_go = 1'b1;
          state_d  = ST_LOAD;
        end
      end
      ST_RDY:  if (panel_rdy_i) state_d = ST_TRIG;
      ST_TRIG: if (fin) state_d = ST_IDLE;
      ST_SRDY: if (panel_rdy_i) state_d = ST_S1;
      ST_S1:   if (fin) state_d = ST_S2;
      ST_S2:   if (fin) state_d = ST_S3;
      ST_S3:   if (fin) begin
        tmr_load = 1'b1;
        tmr_ms   = OFF_MS;
        state_d  = ST_SDLY;
      end
      ST_SDLY: if (tmr_exp) state_d = ST_S4;
      ST_S4:   if (fin) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_IDLE;
      bidx_q  <= 2'd0;
      stage_q <= 2'd0;
      reps_q  <= 7'd0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      bidx_q  <= bidx_d;
      stage_q <= stage_d;
      reps_q  <= reps_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk) begin
    acc_lo_q <= acc_lo_d;
    acc_hi_q <= acc_hi_d;
  end

  // R10: a stalled byte is held unchanged
  assert_hold_R10: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_byte_o) && $stable(wr_cmd_o)));

  // R3: every accepted address byte is followed directly by a data byte
  assert_cmd_then_data_R3: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_valid_o && wr_ready_i && wr_cmd_o) |=> (wr_valid_o && !wr_cmd_o));

  // R7: an aborted sequence emits nothing while the error is shown
  assert_err_quiet_R7: assert property (@(posedge clk) disable iff (!srst_n)
    err_o |-> !wr_valid_o);

  // R8: the trigger write starts only after ready was seen high
  assert_trig_after_rdy_R8: assert property (@(posedge clk) disable iff (!srst_n)
    ($rose(wr_valid_o) && wr_cmd_o && wr_byte_o == REG_TRIG) |-> $past(panel_rdy_i));

  // R11: no byte is offered while idle
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!srst_n)
    !busy_o |-> !wr_valid_o);
endmodule

// File: tb/test_softstart_seq.sv
module test_softstart_seq;
  localparam int CPM  = 3;
  localparam int MAXN = 512;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i, stop_i, panel_rdy_i;
  logic [7:0] cal_addr;
  logic [7:0] cal_data;
  logic       wr_valid, wr_ready, wr_cmd;
  logic [7:0] wr_byte;
  logic       busy, err;

  logic [7:0] cal [0:255];
  bit         bp;
  int         cyc = 0;
  int         n_checks = 0;
  int         n_err = 0;

  logic [7:0] got_b [0:MAXN-1];
  logic       got_c [0:MAXN-1];
  int         got_t [0:MAXN-1];
  int         gn = 0;

  logic [7:0] exp_b [0:MAXN-1];
  logic       exp_c [0:MAXN-1];
  int         exp_g [0:MAXN-1];
  int         exp_n;
  bit         exp_err;

  softstart_seq #(.CAL_AW(8), .CAL_BASE(8'h28), .CLKS_PER_MS(CPM)) i_softstart_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .panel_rdy_i(panel_rdy_i), .cal_addr_o(cal_addr), .cal_data_i(cal_data),
    .wr_valid_o(wr_valid), .wr_ready_i(wr_ready), .wr_cmd_o(wr_cmd),
    .wr_byte_o(wr_byte), .busy_o(busy), .err_o(err)
  );

  always #10 clk = ~clk;

  always @(posedge clk) cal_data <= cal[cal_addr];

  always @(negedge clk) wr_ready <= bp ? (($urandom % 4) != 0) : 1'b1;

  always @(posedge clk) begin
    cyc++;
    if (rst_n && wr_valid && wr_ready && gn < MAXN) begin
      got_b[gn] = wr_byte;
      got_c[gn] = wr_cmd;
      got_t[gn] = cyc;
      gn++;
    end
    if (cyc > 190000) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic push(input logic [7:0] b, input logic c, input int g);
    exp_b[exp_n] = b;
    exp_c[exp_n] = c;
    exp_g[exp_n] = g;
    exp_n++;
  endtask

  // expected stream from the record layout (R2), order (R1, R3), accumulation (R4)
  task automatic build_expected();
    exp_n = 0;
    exp_err = 0;
    for (int s = 0; s < 4; s++) begin
      logic [7:0] r [8];
      logic [7:0] lo, hi;
      int reps, gap;
      for (int k = 0; k < 8; k++) r[k] = cal[8'h28 + 8*s + k];
      if (!r[0][7]) begin
        exp_err = 1;
        break;
      end
      reps = int'(r[0][6:0]);
      lo = r[1];
      hi = r[2];
      for (int i = 0; i < reps; i++) begin
        lo = lo + r[3];
        hi = hi + r[4];
        push(8'h09, 1, 0); push(r[5], 0, 0);
        push(8'h51, 1, 0); push(lo, 0, 0); push(hi, 0, 0);
        gap = (i == reps - 1) ? 0 : (r[7][7] ? int'(r[7][6:0]) * CPM + 3 : 2);
        push(8'h09, 1, 0); push(r[6], 0, gap);
      end
    end
    if (!exp_err) begin
      push(8'h15, 1, 0); push(8'h3C, 0, 0);
    end
  endtask

  task automatic compare(input string tag, input bit strict);
    int bad;
    bad = -1;
    check(gn == exp_n, {tag, " length"}, gn, exp_n);
    for (int i = 0; i < exp_n && i < gn; i++)
      if (bad < 0 && (got_b[i] !== exp_b[i] || got_c[i] !== exp_c[i])) bad = i;
    if (bad >= 0) check(0, {tag, " byte"}, {got_c[bad], got_b[bad]}, {exp_c[bad], exp_b[bad]});
    else          check(1, tag, 0, 0);
    for (int i = 0; i + 1 < exp_n && i + 1 < gn; i++)
      if (exp_g[i] != 0) begin
        int g;
        g = got_t[i+1] - got_t[i];
        check(strict ? (g == exp_g[i]) : (g >= exp_g[i]), "R5 pass gap", g, exp_g[i]);
      end
  endtask

  task automatic wait_until_idle();
    for (int k = 0; k < 60000 && busy; k++) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic run_up(input string tag, input bit strict, input bit poke);
    build_expected();
    gn = 0;
    panel_rdy_i = 1'b0;
    pulse_start();
    check(err == 1'b0, "R7 err cleared by start", err, 0);
    if (poke) begin
      for (int k = 0; k < 60000 && gn < 5; k++) @(negedge clk);
      start_i = 1'b1; stop_i = 1'b1;             // R12: ignored while busy
      @(negedge clk) start_i = 1'b0; stop_i = 1'b0;
    end
    if (exp_err) begin
      wait_until_idle();
      check(err == 1'b1, "R7 err flag", err, 1);
      repeat (10) @(negedge clk);
      compare({tag, " R7 abort"}, strict);
    end else begin
      for (int k = 0; k < 60000 && gn < exp_n - 2; k++) @(negedge clk);
      repeat (20) @(negedge clk);
      check(gn == exp_n - 2 && busy, "R8 waits for ready", gn, exp_n - 2);
      panel_rdy_i = 1'b1;
      wait_until_idle();
      panel_rdy_i = 1'b0;
      repeat (3) @(negedge clk);
      compare(tag, strict);
    end
  endtask

  task automatic put_stage(input int s, input logic [7:0] b0, b1, b2, b3, b4, b5, b6, b7);
    cal[8'h28 + 8*s + 0] = b0; cal[8'h28 + 8*s + 1] = b1;
    cal[8'h28 + 8*s + 2] = b2; cal[8'h28 + 8*s + 3] = b3;
    cal[8'h28 + 8*s + 4] = b4; cal[8'h28 + 8*s + 5] = b5;
    cal[8'h28 + 8*s + 6] = b6; cal[8'h28 + 8*s + 7] = b7;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int a = 0; a < 256; a++) cal[a] = 8'(a ^ 8'hA5);
    rst_n = 1'b0; start_i = 1'b0; stop_i = 1'b0; panel_rdy_i = 1'b0;
    bp = 0; wr_ready = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy == 1'b0, "R11 busy after reset", busy, 0);
    check(wr_valid == 1'b0, "R11 valid after reset", wr_valid, 0);
    check(err == 1'b0, "R11 err after reset", err, 0);

    // directed: wrap-around, negative steps, zero-count stage, both delay modes
    put_stage(0, 8'h83, 8'hFE, 8'h02, 8'h05, 8'hFD, 8'h21, 8'h22, 8'h82);
    put_stage(1, 8'h82, 8'h10, 8'h80, 8'hF0, 8'h7F, 8'h31, 8'h32, 8'h05);
    put_stage(2, 8'h80, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h81); // R6
    put_stage(3, 8'h82, 8'h00, 8'hFF, 8'h01, 8'h01, 8'h41, 8'h42, 8'h80);
    run_up("R1 R2 R3 R4 R6 directed", 1, 0);

    // R12: start/stop pulses mid-run leave the stream unchanged
    run_up("R12 ignored pulses", 1, 1);

    // R7: bad format flag in stage 2
    put_stage(2, 8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h81);
    run_up("R7 abort", 1, 0);

    // R9: stop sequence
    gn = 0;
    panel_rdy_i = 1'b0;
    @(negedge clk) stop_i = 1'b1;
    @(negedge clk) stop_i = 1'b0;
    check(err == 1'b0, "R7 err cleared by stop", err, 0);
    repeat (30) @(negedge clk);
    check(gn == 0 && busy, "R9 waits for ready", gn, 0);
    panel_rdy_i = 1'b1;
    wait_until_idle();
    panel_rdy_i = 1'b0;
    exp_n = 0;
    push(8'h09, 1, 0); push(8'h7B, 0, 0); push(8'h05, 1, 0); push(8'h5D, 0, 0);
    push(8'h09, 1, 0); push(8'h7A, 0, 0); push(8'h09, 1, 0); push(8'h00, 0, 0);
    compare("R9 stop", 1);
    if (gn == 8) check(got_t[6] - got_t[5] == 15 * CPM + 2, "R9 stop pause",
                       got_t[6] - got_t[5], 15 * CPM + 2);

    // random records under random backpressure (R10 held by assertion)
    bp = 1;
    for (int t = 0; t < 6; t++) begin
      for (int s = 0; s < 4; s++)
        put_stage(s, {1'b1, 7'($urandom % 4)}, 8'($urandom), 8'($urandom),
                  8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
                  {1'($urandom), 7'($urandom % 6)});
      run_up("R3 R4 R10 random", 0, 0);
    end
    bp = 0;

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule